// File: doc/BRIEF.md
# Serial Channel Multi-Role Pin Port

This block serves one channel of a multi-channel serial controller. It owns four pads. A 2-bit selector for each pad decides what the pad does. The pad can be a plain input. It can drive the inverse of a bit held in the output register. It can carry the channel's request-to-send or end-of-transmission line. It can also present one of the channel's transmit or receive clocks, at either 1x or 16x rate. Whatever the selector says, each pad level passes through a synchronizer. The synchronized level then goes three ways: back to the channel as clear-to-send, as an external transmit clock and as an external receive clock; to a change-of-state detector; and to a readable status word.

Software programs the port through a small register bus with separate write and read strobes. Address 0 is the pad selector word and address 1 is the control word: detector enables in the upper nibble, output bits in the lower nibble. A read of address 2 returns the status word and clears the latched change flags. Control and status lines are plain levels. No stream data crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_gpio_port`

## Requirements
- R1: After reset the selector word and the control word read 0. All pad_oe bits are 0, irq is 0 and the status change flags are 0.
- R2: Selector code 00 for pad n (selector bits 2n+1:2n) makes the pad an input, so pad_oe[n] is 0.
- R3: Code 01 on pad 0 or pad 3 drives the pad with the inverse of control bit n (bits 3:0 of the control word).
- R4: Clock codes. Pad 0: 10 gives txc1x and 11 gives txc16x. Pad 3: 10 gives txc16x and 11 gives txc1x. Pad 2: 10 gives rxc1x and 11 gives rxc16x. Pad 1: 11 gives rxc1x, and 10 leaves pad 1 undriven.
- R5: Code 01 on pad 2 drives rts_n when mode_rts_en is 1. Otherwise it drives eot_n when mode_eot_en is 1. Otherwise it drives the inverse of control bit 2. The rts_n choice has priority.
- R6: Code 01 on pad 1 drives rts_n when mode_rts_en is 1 and pad 2's code is not 01. In every other case it drives the inverse of control bit 1.
- R7: Status bits 3:0 return the pad levels (1 = high) after a two-flop synchronizer. rd_data is updated on the clock edge that samples rd_en.
- R8: Status bit 4+n latches on any synchronized transition of pad n while detector enable bit 4+n is set. It stays set until a status read, which clears it.
- R9: A change flag reads 0, and stays cleared, while its detector enable is 0 or its pad is driven (pad_oe[n] = 1).
- R10: irq is 1 exactly while any change flag is set.
- R11: cts_n, ext_rxc and ext_txc follow the synchronized levels of pads 0, 2 and 3 for every selector setting.
- R12: Address 0 reads back the selector word, address 1 reads back the control word, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| pad_in | input | 4 | Pad input levels |
| pad_out | output | 4 | Pad output levels |
| pad_oe | output | 4 | Pad output enables |
| txc1x | input | 1 | Transmit clock, 1x rate |
| txc16x | input | 1 | Transmit clock, 16x rate |
| rxc1x | input | 1 | Receive clock, 1x rate |
| rxc16x | input | 1 | Receive clock, 16x rate |
| rts_n | input | 1 | Request-to-send from the channel |
| eot_n | input | 1 | End-of-transmission from the channel |
| mode_rts_en | input | 1 | Route rts_n to a pad |
| mode_eot_en | input | 1 | Route eot_n to pad 2 |
| cts_n | output | 1 | Synchronized pad 0 level |
| ext_rxc | output | 1 | Synchronized pad 2 level |
| ext_txc | output | 1 | Synchronized pad 3 level |
| irq | output | 1 | Any change flag set |

## Verification
The hardest case to reach is a change flag that has to be masked. Here a pad toggles while it is being driven or while its detector is off, and the status read must still show the new level with no flag. To reach it, random rounds program a random selector word and a random control word, clear the flags with one read, then flip a random subset of pads. After enough cycles for the synchronizer and the detector, a second read compares the result with levels and flags predicted from the mask. Directed steps cover the moves of request-to-send between pads 1 and 2 and the reserved code on pad 1.

// File: rtl/uart_gpio_pkg.sv
package uart_gpio_pkg;
  localparam int NPIN   = 4;
  localparam int CODE_W = 2;
  localparam int REG_W  = NPIN * CODE_W;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SEL  = 2'd0,
    ADDR_CTL  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } addr_e;

  typedef enum logic [CODE_W-1:0] {
    CODE_IN   = 2'b00,
    CODE_REG  = 2'b01,
    CODE_ALTA = 2'b10,
    CODE_ALTB = 2'b11
  } code_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import uart_gpio_pkg::*;
#(
  parameter int PIN = 0
) (
  input  logic [CODE_W-1:0] code,
  input  logic              reg_src,
  input  logic              txc1x,
  input  logic              txc16x,
  input  logic              rxc1x,
  input  logic              rxc16x,
  output logic              oe,
  output logic              out
);
  logic alt_a, alt_b, alt_a_ok;

  generate
    if (PIN == 0) begin : g_p0
      assign alt_a = txc1x;  assign alt_b = txc16x; assign alt_a_ok = 1'b1;
    end else if (PIN == 1) begin : g_p1
      assign alt_a = 1'b0;   assign alt_b = rxc1x;  assign alt_a_ok = 1'b0;
    end else if (PIN == 2) begin : g_p2
      assign alt_a = rxc1x;  assign alt_b = rxc16x; assign alt_a_ok = 1'b1;
    end else begin : g_p3
      assign alt_a = txc16x; assign alt_b = txc1x;  assign alt_a_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    oe  = 1'b0;
    out = 1'b0;
    case (code_e'(code))
      CODE_REG:  begin oe = 1'b1;     out = reg_src; end
      CODE_ALTA: begin oe = alt_a_ok; out = alt_a_ok & alt_a; end
      CODE_ALTB: begin oe = 1'b1;     out = alt_b; end
      default:   begin oe = 1'b0;     out = 1'b0; end
    endcase
  end
endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mask,
  input  logic         clr,
  output logic [W-1:0] flags,
  output logic [W-1:0] edge_pulse
);
  logic [W-1:0] prev;

  assign edge_pulse = lvl ^ prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= '0;
      flags <= '0;
    end else begin
      prev  <= lvl;
      flags <= ((clr ? '0 : flags) | edge_pulse) & mask;
    end
  end
endmodule

// File: rtl/uart_gpio_port.sv
module uart_gpio_port
  import uart_gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  input  logic              txc1x,
  input  logic              txc16x,
  input  logic              rxc1x,
  input  logic              rxc16x,
  input  logic              rts_n,
  input  logic              eot_n,
  input  logic              mode_rts_en,
  input  logic              mode_eot_en,
  output logic              cts_n,
  output logic              ext_rxc,
  output logic              ext_txc,
  output logic              irq
);
  logic [REG_W-1:0] sel_q, ctl_q;
  logic [NPIN-1:0]  lvl, flags, edge_pulse, ien, obit, reg_src;
  logic             pin2_reg_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_SEL) sel_q <= wr_data;
      if (wr_addr == ADDR_CTL) ctl_q <= wr_data;
    end
  end

  assign ien  = ctl_q[REG_W-1:NPIN];
  assign obit = ctl_q[NPIN-1:0];
  assign pin2_reg_mode = (sel_q[5:4] == CODE_REG);

  always_comb begin
    reg_src = ~obit;
    if (mode_rts_en)      reg_src[2] = rts_n;
    else if (mode_eot_en) reg_src[2] = eot_n;
    if (mode_rts_en && !pin2_reg_mode) reg_src[1] = rts_n;
  end

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      gpio_pin_mux #(.PIN(i)) u_mux (
        .code    (sel_q[CODE_W*i +: CODE_W]),
        .reg_src (reg_src[i]),
        .txc1x   (txc1x),
        .txc16x  (txc16x),
        .rxc1x   (rxc1x),
        .rxc16x  (rxc16x),
        .oe      (pad_oe[i]),
        .out     (pad_out[i])
      );
    end
  endgenerate

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (pad_in), .q (lvl)
  );

  gpio_change_det #(.W(NPIN)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl        (lvl),
    .mask       (ien & ~pad_oe),
    .clr        (rd_en && (rd_addr == ADDR_STAT)),
    .flags      (flags),
    .edge_pulse (edge_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (addr_e'(rd_addr))
        ADDR_SEL:  rd_data <= sel_q;
        ADDR_CTL:  rd_data <= ctl_q;
        ADDR_STAT: rd_data <= {flags, lvl};
        default:   rd_data <= '0;
      endcase
    end
  end

  assign irq     = |flags;
  assign cts_n   = lvl[0];
  assign ext_rxc = lvl[2];
  assign ext_txc = lvl[3];
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] pad_in,
  input logic [3:0] pad_oe,
  input logic       rd_en,
  input logic [1:0] rd_addr,
  input logic       irq,
  input logic [3:0] lvl,
  input logic [3:0] flags,
  input logic [3:0] edge_pulse,
  input logic [3:0] ien
);
  logic [1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd0) |-> (pad_oe == 4'b0)); // R1

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES == 2 && up_cnt == 2'd3) |-> (lvl == $past(pad_in, 2))); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd2 && edge_pulse == 4'b0) |=> (flags == 4'b0)); // R8

  AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~(ien & ~pad_oe)) == 4'b0); // R9

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 2'd0 && $rose(irq)) |-> ($past(edge_pulse) != 4'b0)); // R10
endmodule

bind uart_gpio_port gpio_port_checker #(.STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pad_in     (pad_in),
  .pad_oe     (pad_oe),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .irq        (irq),
  .lvl        (lvl),
  .flags      (flags),
  .edge_pulse (edge_pulse),
  .ien        (ctl_q[7:4])
);

// File: tb/sim_uart_gpio_port.sv
module sim_uart_gpio_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [3:0] pad_in = 0, pad_out, pad_oe;
  logic txc1x = 0, txc16x = 0, rxc1x = 0, rxc16x = 0, rts_n = 1, eot_n = 1;
  logic mode_rts_en = 0, mode_eot_en = 0;
  logic cts_n, ext_rxc, ext_txc, irq;
  int checks = 0, errors = 0;
  logic [7:0] m_sel = 0, m_ctl = 0;

  always #4 clk = ~clk;

  uart_gpio_port u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (a == 0) m_sel = d;
    if (a == 1) m_ctl = d;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  function automatic logic [7:0] exp_pads();
    logic [3:0] oe, out;
    logic [1:0] c;
    logic src;
    for (int i = 0; i < 4; i++) begin
      c = m_sel[2*i +: 2];
      src = ~m_ctl[i];
      if (i == 2 && mode_rts_en) src = rts_n;
      else if (i == 2 && mode_eot_en) src = eot_n;
      if (i == 1 && mode_rts_en && m_sel[5:4] != 2'b01) src = rts_n;
      oe[i] = 1'b1; out[i] = 1'b0;
      case (c)
        2'b00: oe[i] = 1'b0;
        2'b01: out[i] = src;
        2'b10: case (i)
                 0: out[i] = txc1x;
                 1: oe[i] = 1'b0;
                 2: out[i] = rxc1x;
                 default: out[i] = txc16x;
               endcase
        default: case (i)
                 0: out[i] = txc16x;
                 1: out[i] = rxc1x;
                 2: out[i] = rxc16x;
                 default: out[i] = txc1x;
               endcase
      endcase
    end
    return {oe, out};
  endfunction

  task automatic chk_pads(input string req);
    @(negedge clk);
    chk(req, {pad_oe, pad_out}, exp_pads());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [3:0] old_p, new_p, mask;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 4'h0);
    chk("R1 irq", irq, 1'b0);
    rd(0, d); chk("R1 sel", d, 8'h00);
    rd(1, d); chk("R1 ctl", d, 8'h00);
    rd(2, d); chk("R1 status", d, 8'h00);

    // R8 R10: enabled inputs latch flags, read clears
    wr(1, 8'hF0); rd(2, d);
    pad_in = 4'b0101; repeat (4) @(negedge clk);
    chk("R10 irq set", irq, 1'b1);
    rd(2, d); chk("R8 flags+R7 level", d, 8'h55);
    chk("R10 irq clear", irq, 1'b0);
    rd(2, d); chk("R8 cleared", d, 8'h05);
    chk("R11 cts", cts_n, 1'b1);
    chk("R11 rxc", ext_rxc, 1'b1);
    chk("R11 txc", ext_txc, 1'b0);

    // R9: disabled detector and driven pad
    wr(1, 8'h00); pad_in = 4'b1100; repeat (4) @(negedge clk);
    rd(2, d); chk("R9 disabled", d, 8'h0C);
    wr(1, 8'h10); wr(0, 8'h01); pad_in = 4'b1101; repeat (4) @(negedge clk);
    rd(2, d); chk("R9 output pad", d, 8'h0D);
    chk("R11 cts on driven pad", cts_n, 1'b1);

    // R5 R6 directed
    rts_n = 0; eot_n = 1; mode_rts_en = 1; mode_eot_en = 1;
    wr(1, 8'h00); wr(0, 8'h14); chk_pads("R5 rts on pad2");
    chk("R6 pad1 reg when pad2 has rts", pad_out[1], 1'b1);
    mode_rts_en = 0; chk_pads("R5 eot on pad2");
    mode_eot_en = 0; chk_pads("R5 reg on pad2");
    mode_rts_en = 1; wr(0, 8'h04); chk_pads("R6 rts moves to pad1");
    chk("R6 pad1 level", pad_out[1], 1'b0);
    wr(0, 8'h08); chk("R4 pad1 code 10", pad_oe[1], 1'b0);
    wr(0, 8'h00); chk_pads("R2 all inputs");
    wr(0, 8'hA5); wr(1, 8'h3C);
    rd(0, d); chk("R12 sel", d, 8'hA5);
    rd(1, d); chk("R12 ctl", d, 8'h3C);
    rd(3, d); chk("R12 addr3", d, 8'h00);

    // random rounds
    for (int it = 0; it < 150; it++) begin
      txc1x = 1'($urandom); txc16x = 1'($urandom);
      rxc1x = 1'($urandom); rxc16x = 1'($urandom);
      rts_n = 1'($urandom); eot_n = 1'($urandom);
      mode_rts_en = 1'($urandom); mode_eot_en = 1'($urandom);
      wr(0, 8'($urandom)); wr(1, 8'($urandom));
      chk_pads("R3 R4 R5 R6 random pads");
      rd(2, d);
      old_p = pad_in;
      new_p = old_p ^ 4'($urandom);
      pad_in = new_p;
      repeat (4) @(negedge clk);
      mask = m_ctl[7:4] & ~exp_pads()[7:4];
      chk("R10 random irq", irq, |((old_p ^ new_p) & mask));
      rd(2, d);
      chk("R7 R8 R9 random status", d, {(old_p ^ new_p) & mask, new_p});
      chk("R11 random taps", {ext_txc, ext_rxc, cts_n}, {new_p[3], new_p[2], new_p[0]});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule